// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small 8-bit microcontroller core through its two reduced-power states. In the sleep state the core clock is gated while the oscillator keeps running, and the peripheral counter either runs on or pauses, as software chooses. In the deep-stop state the oscillator itself is switched off. The block gates the core clock, enables the oscillator, and models oscillator readiness with a settle counter. It blocks internal RAM writes during the reset hand-over that follows sleep, strobes the special-function-register reset, and tells the pad logic how to drive the address-latch strobe, the program-fetch strobe and the two shared ports.

The block has no data stream. Every pin is a plain level or a one-cycle pulse, with no handshake and no back-pressure. Software raises `sleep_req` or `stop_req` for one cycle to enter a state. Two external interrupt pins, active low, each carry an enable and a trigger-type setting. Every other enabled interrupt is merged into `irq_any`. After an exit by interrupt, `wake_pulse` tells the vectoring logic to service the pending request. Execution then carries on after the instruction that entered the state.

Top module: `lpm_sequencer`

## Requirements
- R1: Out of reset the block is in the run state: `cpu_clk_en`, `osc_en` and `osc_ready` are 1, `ram_wr_inhibit` is 0 and both port modes are 0 (hold data). A `sleep_req` in the run state clears `cpu_clk_en` on the next cycle, and `osc_en` stays 1.
- R2: In sleep, `pcnt_run_en` equals `pcnt_sleep_run`. It is 1 in run and 0 in deep-stop.
- R3: Sleep ends one cycle after any of the following: `irq_any`; an enabled level-type external pin that is low; an enabled edge-type pin that was high in the previous cycle and is low now. A disabled external pin does not end sleep.
- R4: A `stop_req` clears `osc_en` and `cpu_clk_en` on the next cycle. When `sleep_req` and `stop_req` arrive in the same cycle, deep-stop wins. `cpu_clk_en` is never 1 while `osc_en` is 0.
- R5: In deep-stop, `irq_any`, a disabled external pin and an enabled edge-type external pin have no effect: `osc_en` and `cpu_clk_en` stay 0.
- R6: An enabled level-type external pin held low in deep-stop sets `osc_en` on the next cycle. The core clock stays off until that pin returns high.
- R7: After restart, `osc_ready` rises after `settle_cycles` cycles with `osc_en` high. If `settle_cycles` is zero, the parameter `SETTLE_DFLT` is used instead. Deep-stop is left on the first cycle in which `osc_ready` is 1 and no qualifying pin is low.
- R8: Each exit by interrupt, from sleep or from deep-stop, raises `wake_pulse` for exactly one cycle, in the same cycle that `cpu_clk_en` returns. No other event raises it.
- R9: A rising `hw_reset` in run or deep-stop puts the block in run on the next cycle, raises `sfr_reset` for one cycle and does not raise `wake_pulse`.
- R10: `hw_reset` in sleep wins over a wake-up in the same cycle. The core clock then runs with `ram_wr_inhibit` at 1 for `GUARD_MC*MC_CLKS` cycles (24 by default). After that `ram_wr_inhibit` returns to 0 and `sfr_reset` pulses in the same cycle.
- R11: `ale_lvl` and `psen_lvl` are 1 in sleep and 0 in deep-stop, including during the oscillator restart.
- R12: Port modes use the codes 0 = hold data, 1 = float, 2 = drive address. With external program memory (`ext_code` = 1), port 0 floats in both low-power states, and port 2 drives address in sleep and holds data in deep-stop. In every other case both ports hold data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_reset | input | 1 | Hardware reset pin, synchronous, active high |
| sleep_req | input | 1 | Software request for sleep |
| stop_req | input | 1 | Software request for deep-stop |
| ext_irq_n | input | NUM_EXT | External interrupt pins, active low |
| ext_irq_en | input | NUM_EXT | Enable for each external interrupt |
| ext_irq_lvl | input | NUM_EXT | 1 = level-type, 0 = edge-type |
| irq_any | input | 1 | Any other enabled interrupt pending |
| ext_code | input | 1 | 1 = program memory is external |
| pcnt_sleep_run | input | 1 | Peripheral counter keeps running in sleep |
| settle_cycles | input | CNT_W | Oscillator settle count, 0 selects SETTLE_DFLT |
| cpu_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| osc_ready | output | 1 | Oscillator settled |
| pcnt_run_en | output | 1 | Peripheral counter run enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| sfr_reset | output | 1 | One-cycle register reset strobe |
| wake_pulse | output | 1 | One-cycle wake-up notice to the interrupt logic |
| ale_lvl | output | 1 | Address-latch strobe level in low power |
| psen_lvl | output | 1 | Program-fetch strobe level in low power |
| port0_mode | output | 2 | Port 0 drive mode |
| port2_mode | output | 2 | Port 2 drive mode |

## Verification
A hardware reset and an interrupt wake-up can both arrive in a cycle where the block is asleep. The bench raises `hw_reset` and `irq_any` on the same clock edge while the block sleeps. The reset must win: the RAM-write guard must last the full 24 cycles, `sfr_reset` must pulse when the guard ends, and the scoreboard must never see a `wake_pulse`. The other collision is a sleep request and a deep-stop request in one cycle, which is judged by `osc_en` falling on the next edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STOP    = 3'd2,
    ST_RESTART = 3'd3,
    ST_GUARD   = 3'd4
  } lpm_state_e;

  typedef enum logic [1:0] {
    PM_DATA  = 2'd0,
    PM_FLOAT = 2'd1,
    PM_ADDR  = 2'd2
  } port_mode_e;
endpackage

// File: rtl/lpm_settle_ctr.sv
module lpm_settle_ctr #(
  parameter int CNT_W       = 24,
  parameter int SETTLE_DFLT = 120000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             osc_ready
);
  localparam logic [CNT_W:0] DFLT_W = (CNT_W+1)'(SETTLE_DFLT);

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;
  logic [CNT_W:0]   limit;
  logic [CNT_W:0]   cnt_inc;

  assign limit   = (settle_cycles == '0) ? DFLT_W : {1'b0, settle_cycles};
  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else if (!osc_en) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_inc >= limit) ready_q <= 1'b1;
      else                  cnt_q   <= cnt_inc[CNT_W-1:0];
    end
  end

  assign osc_ready = ready_q;

  AST_READY_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && $past(!osc_en)) |-> !osc_ready); // R7
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic [NUM_EXT-1:0] ext_irq_en,
  input  logic [NUM_EXT-1:0] ext_irq_lvl,
  input  logic               irq_any,
  output logic               sleep_wake,
  output logic               stop_hold
);
  logic [NUM_EXT-1:0] pin_q;
  logic [NUM_EXT-1:0] lvl_hit;
  logic [NUM_EXT-1:0] edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '1;
    else        pin_q <= ext_irq_n;
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
    assign lvl_hit[g]  = ext_irq_en[g] &  ext_irq_lvl[g] & ~ext_irq_n[g];
    assign edge_hit[g] = ext_irq_en[g] & ~ext_irq_lvl[g] & pin_q[g] & ~ext_irq_n[g];
  end

  assign sleep_wake = irq_any | (|lvl_hit) | (|edge_hit);
  assign stop_hold  = |lvl_hit;

  AST_HOLD_NEEDS_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hold |-> (ext_irq_n != '1)); // R6
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       ext_code,
  output logic       ale_lvl,
  output logic       psen_lvl,
  output logic [1:0] port0_mode,
  output logic [1:0] port2_mode
);
  logic in_sleep;
  logic in_stop;

  assign in_sleep = (state == ST_SLEEP);
  assign in_stop  = (state == ST_STOP) || (state == ST_RESTART);

  always_comb begin
    ale_lvl    = 1'b1;
    psen_lvl   = 1'b1;
    port0_mode = PM_DATA;
    port2_mode = PM_DATA;
    if (in_stop) begin
      ale_lvl  = 1'b0;
      psen_lvl = 1'b0;
    end
    if (ext_code && (in_sleep || in_stop)) port0_mode = PM_FLOAT;
    if (ext_code && in_sleep)              port2_mode = PM_ADDR;
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_EXT     = 2,
  parameter int CNT_W       = 24,
  parameter int SETTLE_DFLT = 120000,
  parameter int MC_CLKS     = 12,
  parameter int GUARD_MC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_reset,
  input  logic               sleep_req,
  input  logic               stop_req,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic [NUM_EXT-1:0] ext_irq_en,
  input  logic [NUM_EXT-1:0] ext_irq_lvl,
  input  logic               irq_any,
  input  logic               ext_code,
  input  logic               pcnt_sleep_run,
  input  logic [CNT_W-1:0]   settle_cycles,
  output logic               cpu_clk_en,
  output logic               osc_en,
  output logic               osc_ready,
  output logic               pcnt_run_en,
  output logic               ram_wr_inhibit,
  output logic               sfr_reset,
  output logic               wake_pulse,
  output logic               ale_lvl,
  output logic               psen_lvl,
  output logic [1:0]         port0_mode,
  output logic [1:0]         port2_mode
);
  localparam int GUARD_CYC = MC_CLKS * GUARD_MC;
  localparam int GW        = $clog2(GUARD_CYC + 1);
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYC - 1);

  lpm_state_e state_q, state_d;
  logic [GW-1:0] guard_q;
  logic guard_done, sleep_wake, stop_hold, hw_q, hw_rise;
  logic stop_exit, wake_d, sfr_d;

  lpm_wake_qual #(.NUM_EXT(NUM_EXT)) u_wake (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .ext_irq_en(ext_irq_en),
    .ext_irq_lvl(ext_irq_lvl), .irq_any(irq_any),
    .sleep_wake(sleep_wake), .stop_hold(stop_hold)
  );

  lpm_settle_ctr #(.CNT_W(CNT_W), .SETTLE_DFLT(SETTLE_DFLT)) u_settle (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .settle_cycles(settle_cycles), .osc_ready(osc_ready)
  );

  lpm_pin_ctrl u_pins (
    .state(state_q), .ext_code(ext_code), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl),
    .port0_mode(port0_mode), .port2_mode(port2_mode)
  );

  assign guard_done = (guard_q == GUARD_LAST);
  assign hw_rise    = hw_reset & ~hw_q;
  assign stop_exit  = osc_ready & ~stop_hold;

  always_comb begin
    state_d = state_q;
    if (hw_reset) begin
      if (state_q == ST_SLEEP || state_q == ST_GUARD) state_d = ST_GUARD;
      else                                            state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN:     if (stop_req) state_d = ST_STOP;
                    else if (sleep_req) state_d = ST_SLEEP;
        ST_SLEEP:   if (sleep_wake) state_d = ST_RUN;
        ST_STOP:    if (stop_hold) state_d = ST_RESTART;
        ST_RESTART: if (stop_exit) state_d = ST_RUN;
        ST_GUARD:   if (guard_done) state_d = ST_RUN;
        default:    state_d = ST_RUN;
      endcase
    end
  end

  assign wake_d = !hw_reset && (((state_q == ST_SLEEP) && sleep_wake) ||
                                ((state_q == ST_RESTART) && stop_exit));
  assign sfr_d  = (hw_rise && state_q != ST_SLEEP && state_q != ST_GUARD) ||
                  (!hw_reset && state_q == ST_GUARD && guard_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      guard_q    <= '0;
      hw_q       <= 1'b0;
      wake_pulse <= 1'b0;
      sfr_reset  <= 1'b0;
    end else begin
      state_q    <= state_d;
      hw_q       <= hw_reset;
      wake_pulse <= wake_d;
      sfr_reset  <= sfr_d;
      if (state_q != ST_GUARD) guard_q <= '0;
      else if (!guard_done)    guard_q <= guard_q + 1'b1;
    end
  end

  assign cpu_clk_en     = (state_q == ST_RUN) || (state_q == ST_GUARD);
  assign osc_en         = (state_q != ST_STOP);
  assign ram_wr_inhibit = (state_q == ST_GUARD);
  always_comb begin
    case (state_q)
      ST_RUN, ST_GUARD: pcnt_run_en = 1'b1;
      ST_SLEEP:         pcnt_run_en = pcnt_sleep_run;
      default:          pcnt_run_en = 1'b0;
    endcase
  end

  AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !cpu_clk_en); // R4
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && stop_req && !hw_reset) |=> !osc_en); // R4
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R8
  AST_WAKE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (osc_ready && cpu_clk_en)); // R7
  AST_WAKE_NOT_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !sfr_reset); // R9
  AST_INHIBIT_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_inhibit) |-> $past(hw_reset)); // R10
  AST_STOP_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!ale_lvl && !psen_lvl)); // R11
  AST_ADDR_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (port2_mode == PM_ADDR) |-> (ext_code && !cpu_clk_en && osc_en)); // R12
endmodule

// File: tb/lpm_sequencer_tb_top.sv
`timescale 1ns/1ps
module lpm_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_reset = 1'b0, sleep_req = 1'b0, stop_req = 1'b0;
  logic [1:0] ext_irq_n = 2'b11, ext_irq_en = 2'b00, ext_irq_lvl = 2'b00;
  logic irq_any = 1'b0, ext_code = 1'b0, pcnt_sleep_run = 1'b0;
  logic [23:0] settle_cycles = 24'd20;
  logic cpu_clk_en, osc_en, osc_ready, pcnt_run_en, ram_wr_inhibit;
  logic sfr_reset, wake_pulse, ale_lvl, psen_lvl;
  logic [1:0] port0_mode, port2_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  byte exp_q[$];

  always #2.5 clk = ~clk;

  lpm_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .sleep_req(sleep_req),
    .stop_req(stop_req), .ext_irq_n(ext_irq_n), .ext_irq_en(ext_irq_en),
    .ext_irq_lvl(ext_irq_lvl), .irq_any(irq_any), .ext_code(ext_code),
    .pcnt_sleep_run(pcnt_sleep_run), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .osc_ready(osc_ready),
    .pcnt_run_en(pcnt_run_en), .ram_wr_inhibit(ram_wr_inhibit),
    .sfr_reset(sfr_reset), .wake_pulse(wake_pulse), .ale_lvl(ale_lvl),
    .psen_lvl(psen_lvl), .port0_mode(port0_mode), .port2_mode(port2_mode)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every strobe seen must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wake_pulse) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0] != "W") begin
          errors++;
          $display("FAIL R8 actual=wake expected=%s",
                   exp_q.size() == 0 ? "none" : "sfr");
        end
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
      if (sfr_reset) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0] != "S") begin
          errors++;
          $display("FAIL R9 actual=sfr expected=%s",
                   exp_q.size() == 0 ? "none" : "wake");
        end
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 clk", cpu_clk_en, 1); chk("R1 osc", osc_en, 1);
    chk("R1 ready", osc_ready, 1); chk("R1 inhibit", ram_wr_inhibit, 0);
    chk("R1 p0", port0_mode, 0); chk("R1 p2", port2_mode, 0);

    // Sleep, internal code, counter kept running, woken by other interrupt
    pcnt_sleep_run = 1'b1; sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    chk("R1 sleep clk", cpu_clk_en, 0); chk("R1 sleep osc", osc_en, 1);
    chk("R2 run", pcnt_run_en, 1);
    chk("R11 ale", ale_lvl, 1); chk("R11 psen", psen_lvl, 1);
    chk("R12 p0 int", port0_mode, 0); chk("R12 p2 int", port2_mode, 0);
    irq_any = 1'b1; exp_q.push_back("W"); step(1); irq_any = 1'b0;
    chk("R3 irq wake", cpu_clk_en, 1); chk("R8 pulse", wake_pulse, 1);
    step(1); chk("R8 one cycle", wake_pulse, 0);

    // Sleep, external code, counter paused
    ext_code = 1'b1; pcnt_sleep_run = 1'b0;
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    chk("R2 paused", pcnt_run_en, 0);
    chk("R12 p0 float", port0_mode, 1); chk("R12 p2 addr", port2_mode, 2);
    ext_irq_n = 2'b10; step(3);
    chk("R3 disabled pin", cpu_clk_en, 0);
    ext_irq_n = 2'b11; ext_irq_en = 2'b10; ext_irq_lvl = 2'b00; step(1);
    ext_irq_n = 2'b01; exp_q.push_back("W"); step(1);
    chk("R3 edge wake", cpu_clk_en, 1);
    ext_irq_n = 2'b11; step(2);

    // Both requests together: deep-stop wins
    pcnt_sleep_run = 1'b1;
    sleep_req = 1'b1; stop_req = 1'b1; step(1); sleep_req = 1'b0; stop_req = 1'b0;
    chk("R4 osc off", osc_en, 0); chk("R4 clk off", cpu_clk_en, 0);
    chk("R2 stop paused", pcnt_run_en, 0);
    chk("R11 ale low", ale_lvl, 0); chk("R11 psen low", psen_lvl, 0);
    chk("R12 p0 float", port0_mode, 1); chk("R12 p2 data", port2_mode, 0);

    // Ignored sources in deep-stop
    irq_any = 1'b1; ext_irq_en = 2'b10; ext_irq_lvl = 2'b01; ext_irq_n = 2'b00;
    step(5);
    chk("R5 osc", osc_en, 0); chk("R5 clk", cpu_clk_en, 0);
    irq_any = 1'b0; ext_irq_n = 2'b11; step(1);

    // Level pin held long
    ext_irq_en = 2'b01; ext_irq_lvl = 2'b01; ext_irq_n = 2'b10; step(1);
    chk("R6 osc restart", osc_en, 1); chk("R6 clk off", cpu_clk_en, 0);
    chk("R11 restart ale", ale_lvl, 0);
    step(30);
    chk("R6 held", cpu_clk_en, 0); chk("R7 ready", osc_ready, 1);
    ext_irq_n = 2'b11; exp_q.push_back("W"); step(1);
    chk("R6 exit", cpu_clk_en, 1); chk("R8 pulse", wake_pulse, 1);
    step(1); chk("R8 one cycle", wake_pulse, 0);

    // Early release: exit waits for settle count
    ext_code = 1'b0;
    stop_req = 1'b1; step(1); stop_req = 1'b0; step(3);
    ext_irq_n = 2'b10; step(1); ext_irq_n = 2'b11;
    step(19);
    chk("R7 not ready", osc_ready, 0); chk("R7 clk off", cpu_clk_en, 0);
    step(1);
    chk("R7 ready", osc_ready, 1); chk("R7 still off", cpu_clk_en, 0);
    exp_q.push_back("W"); step(1);
    chk("R7 exit", cpu_clk_en, 1);
    step(1);

    // Reset in run
    hw_reset = 1'b1; exp_q.push_back("S"); step(1); hw_reset = 1'b0;
    chk("R9 run", cpu_clk_en, 1); chk("R9 strobe", sfr_reset, 1);
    step(1);

    // Reset in deep-stop
    stop_req = 1'b1; step(1); stop_req = 1'b0; step(3);
    hw_reset = 1'b1; exp_q.push_back("S"); step(1); hw_reset = 1'b0;
    chk("R9 stop to run", cpu_clk_en, 1); chk("R9 osc", osc_en, 1);
    step(25);

    // Reset and wake in the same cycle of sleep
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    irq_any = 1'b1; hw_reset = 1'b1; step(1); irq_any = 1'b0; hw_reset = 1'b0;
    chk("R10 inhibit", ram_wr_inhibit, 1); chk("R10 clk", cpu_clk_en, 1);
    step(23);
    chk("R10 inhibit end", ram_wr_inhibit, 1);
    exp_q.push_back("S"); step(1);
    chk("R10 released", ram_wr_inhibit, 0); chk("R10 strobe", sfr_reset, 1);
    step(2);

    chk("R8 queue empty", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule